// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to a usable state. A start pulse switches the memory clock on and holds auto-refresh off. The block then waits a stabilization period of 200 microseconds, counted in clock cycles. After the wait it issues a fixed list of commands with idle slots between them: one precharge-all, eight auto-refreshes and a mode-register load.

The value loaded into the mode register comes from three configuration inputs: a 2-bit latency code, a clock-speed select and a bus-width select. The meaning of the latency code depends on the speed select. A nonzero explicit mode value on the configuration input replaces the computed one. The whole procedure runs twice: wait, commands, then a one-cycle restore of the normal timing with refresh enabled. After the second pass the block raises a sticky done flag and leaves refresh enabled. A memory controller holds off its own traffic until done is high.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset (rst_n low) is held and after it is released, the command outputs are deselected (cs_n, ras_n, cas_n, we_n all 1), addr is 0, and mem_clk_en, refresh_en, busy and done are all 0.
- R2: The cycle after start is sampled high in idle, mem_clk_en goes high and stays high. Exactly CLK_MHZ*WAIT_US cycles pass, with cs_n high, before the first command of each pass.
- R3: Each pass issues exactly ten commands in this order: one precharge, eight auto-refreshes, then one mode-register load. Each real command is followed by one no-op slot, and no-op slots keep cs_n high.
- R4: Command encoding with cs_n=0: precharge is ras_n=0, cas_n=1, we_n=0 with addr[10]=1. Auto-refresh is ras_n=0, cas_n=0, we_n=1. Mode-register load is ras_n=0, cas_n=0, we_n=0. Outside command cycles, cs_n=ras_n=cas_n=we_n=1.
- R5: Each slot lasts 1+GAP_CYCLES cycles. Within a pass, successive real commands are therefore exactly 2*(GAP_CYCLES+1) cycles apart, and never fewer than GAP_CYCLES idle cycles separate two commands.
- R6: When cfg_mode_override is 0, the mode-register load drives addr[7:0] = 0x40 for latency 2 or 0x60 for latency 3, halved (0x20 / 0x30) when cfg_bus32=0. The upper addr bits are 0.
- R7: Latency decode: with cfg_fast=1, cas code 0 means latency 2. With cfg_fast=0, cas code 1 means latency 2. Every other code means latency 3.
- R8: A nonzero cfg_mode_override is driven unchanged on addr[7:0] during the mode-register load, regardless of the other configuration inputs.
- R9: refresh_en is 0 during the waits and commands. It is 1 for exactly one restore cycle at the end of each pass, and stays 1 once done.
- R10: The sequence runs two passes. done rises after the second restore and stays high with no further commands until reset. busy is high from the cycle after start until done.
- R11: start is ignored while busy or done. Holding it high never restarts or lengthens the sequence.
- R12: Asserting reset in the middle of the sequence returns the block to the R1 state. A later start runs a complete, correct sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence from idle |
| cfg_cas_code | input | 2 | Latency code, meaning depends on cfg_fast |
| cfg_fast | input | 1 | 1 = fast (100 MHz) clock, 0 = slow (50 MHz) |
| cfg_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_mode_override | input | 8 | Explicit mode value, 0 = compute |
| mem_clk_en | output | 1 | Memory clock enable |
| refresh_en | output | 1 | Normal auto-refresh permitted |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus, carries mode data and precharge-all bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky |

## Verification
Two events can land in the same cycle here: a start request and an active sequence step. These include a command issue, the restore that turns refresh on between passes, and the done state. The bench holds start high through every run and afterwards. It then checks that the command count stays at exactly twenty, the restore count at two, and the pass spacing at its exact value. A second collision, reset arriving while a refresh command is on the pins, is provoked by counting commands and pulling reset at the third one. The bench then checks the deselected outputs and a clean follow-up run.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_MHZ    = 100,
  parameter int WAIT_US    = 200,
  parameter int GAP_CYCLES = 5,
  parameter int REFRESHES  = 8,
  parameter int PASSES     = 2,
  parameter int ADDR_W     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_cas_code,
  input  logic              cfg_fast,
  input  logic              cfg_bus32,
  input  logic [7:0]        cfg_mode_override,
  output logic              mem_clk_en,
  output logic              refresh_en,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int CNT_MAX  = (WAIT_CYC > GAP_CYCLES) ? WAIT_CYC : GAP_CYCLES;
  localparam int CNT_W    = $clog2(CNT_MAX + 1) + 1;
  localparam int SLOTS    = 2 * (REFRESHES + 2);
  localparam int SLOT_W   = $clog2(SLOTS) + 1;
  localparam int PASS_W   = $clog2(PASSES) + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CMD, S_GAP, S_RESTORE, S_DONE} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [SLOT_W-1:0]   slot;
  logic [PASS_W-1:0]   pass;
  logic [1:0]          code;
  logic                lat3;
  logic [7:0]          mode_calc, mode_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      slot  <= '0;
      pass  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_WAIT;
          cnt   <= '0;
          pass  <= '0;
        end
        S_WAIT: if (cnt == CNT_W'(WAIT_CYC - 1)) begin
          state <= S_CMD;
          slot  <= '0;
        end else cnt <= cnt + 1'b1;
        S_CMD: begin
          state <= S_GAP;
          cnt   <= '0;
        end
        S_GAP: if (cnt == CNT_W'(GAP_CYCLES - 1)) begin
          if (slot == SLOT_W'(SLOTS - 1)) state <= S_RESTORE;
          else begin
            slot  <= slot + 1'b1;
            state <= S_CMD;
          end
        end else cnt <= cnt + 1'b1;
        S_RESTORE: if (pass == PASS_W'(PASSES - 1)) state <= S_DONE;
        else begin
          pass  <= pass + 1'b1;
          cnt   <= '0;
          state <= S_WAIT;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    if (state != S_CMD || slot[0])        code = 2'd0;
    else if (slot == '0)                  code = 2'd3;
    else if (slot == SLOT_W'(SLOTS - 2))  code = 2'd1;
    else                                  code = 2'd2;
  end

  assign lat3      = cfg_fast ? (cfg_cas_code != 2'd0) : (cfg_cas_code != 2'd1);
  assign mode_calc = (8'h40 | (lat3 ? 8'h20 : 8'h00)) >> (cfg_bus32 ? 0 : 1);
  assign mode_val  = (cfg_mode_override != 8'h00) ? cfg_mode_override : mode_calc;

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    addr = '0;
    case (code)
      2'd3: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr[10] = 1'b1; end
      2'd2: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      2'd1: begin {cs_n, ras_n, cas_n, we_n} = 4'b0000; addr[7:0] = mode_val; end
      default: ;
    endcase
  end

  assign mem_clk_en = (state != S_IDLE);
  assign refresh_en = (state == S_RESTORE) || (state == S_DONE);
  assign busy       = (state != S_IDLE) && (state != S_DONE);
  assign done       = (state == S_DONE);
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int GAP_CYCLES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] cfg_mode_override,
  input logic       mem_clk_en,
  input logic       refresh_en,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [7:0] addr_lo,
  input logic       addr10,
  input logic       busy,
  input logic       done
);
  logic [7:0] since;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (!cs_n) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (since != 8'hff) since <= since + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> cs_n && !busy && !done && !mem_clk_en);
  assert_cmd_uses_ras_R4: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> !ras_n);
  assert_precharge_all_R4: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && cas_n) |-> (!we_n && addr10));
  assert_cmd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && seen) |-> since >= 8'(GAP_CYCLES));
  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n && cfg_mode_override != 8'h00) |-> addr_lo == cfg_mode_override);
  assert_no_refresh_in_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> (!refresh_en && mem_clk_en && busy));
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n) done |=> done && cs_n);
  assert_busy_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode_override(cfg_mode_override),
  .mem_clk_en(mem_clk_en), .refresh_en(refresh_en), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr_lo(addr[7:0]), .addr10(addr[10]),
  .busy(busy), .done(done)
);

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 1, WUS = 30, GAP = 5, AW = 13;
  localparam int WAITC = MHZ * WUS;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cas_code = 0;
  logic fast = 0, bus32 = 0;
  logic [7:0] ovr = 0;
  logic mem_clk_en, refresh_en, cs_n, ras_n, cas_n, we_n, busy, done;
  logic [AW-1:0] addr;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_powerup_seq #(.CLK_MHZ(MHZ), .WAIT_US(WUS), .GAP_CYCLES(GAP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cas_code(cas_code), .cfg_fast(fast),
    .cfg_bus32(bus32), .cfg_mode_override(ovr), .mem_clk_en(mem_clk_en), .refresh_en(refresh_en),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; start = 0;
    @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b1111 && addr == 0, "R1 cmd idle in reset", {cs_n, ras_n, cas_n, we_n}, 15);
    check({mem_clk_en, refresh_en, busy, done} == 4'b0000, "R1 flags in reset", {mem_clk_en, refresh_en, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check({cs_n, mem_clk_en, busy, done} == 4'b1000, "R1 after release", {cs_n, mem_clk_en, busy, done}, 8);
  endtask

  function automatic int exp_mode(input int code, input bit f, input bit b32, input int ov);
    bit lat2;
    int m;
    if (ov != 0) return ov;
    lat2 = f ? (code == 0) : (code == 1);
    m = lat2 ? 64 : 96;
    if (!b32) m = m / 2;
    return m;
  endfunction

  task automatic run_seq(input int abort_at);
    int ncmd = 0, nrest = 0, idle_run = 0, t = 0;
    bit bad_order = 0, bad_space = 0, bad_mode = 0, bad_clk = 0;
    int em = exp_mode(cas_code, fast, bus32, ovr);
    @(negedge clk); start = 1;
    @(negedge clk);
    check(mem_clk_en && busy && cs_n, "R2 clock on after start", {mem_clk_en, busy, cs_n}, 7);
    while (!done && t < 3000) begin
      t++;
      if (!mem_clk_en) bad_clk = 1;
      if (refresh_en && busy) begin
        nrest++;
        if (ncmd != 10 * nrest) bad_order = 1;
        idle_run = 0;
      end else if (!cs_n) begin
        int k = ncmd % 10;
        int want = (k == 0) ? 2 : 0;
        int seen;
        if (k == 0 && idle_run != WAITC) begin
          bad_space = 1;
          check(0, "R2 wait length", idle_run, WAITC);
        end
        if (k != 0 && idle_run != 2 * (GAP + 1) - 1) begin
          bad_space = 1;
          check(0, "R5 command spacing", idle_run, 2 * (GAP + 1) - 1);
        end
        seen = {ras_n, cas_n, we_n};
        if (k == 0) want = 3'b010; else if (k == 9) want = 3'b000; else want = 3'b001;
        if (seen != want || (k == 0 && !addr[10])) begin
          bad_order = 1;
          check(0, "R3/R4 command code", seen, want);
        end
        if (k == 9 && addr != AW'(em)) bad_mode = 1;
        if (k == 9) check(addr == AW'(em), ovr != 0 ? "R8 override mode" : "R6/R7 mode value", int'(addr), em);
        if (refresh_en) bad_order = 1;
        ncmd++;
        idle_run = 0;
        if (abort_at != 0 && ncmd == abort_at) begin
          rst_n = 0;
          #1;
          check(cs_n && !busy && !mem_clk_en && !done && addr == 0, "R12 reset mid-sequence", {cs_n, busy, mem_clk_en, done}, 8);
          start = 0;
          @(negedge clk); rst_n = 1;
          @(negedge clk);
          check(cs_n && !busy && !done, "R12 idle after abort", {cs_n, busy, done}, 4);
          return;
        end
      end else begin
        idle_run++;
        if (refresh_en) bad_order = 1;
      end
      @(negedge clk);
    end
    check(done, "R10 done reached", done, 1);
    check(ncmd == 20, "R3 total commands", ncmd, 20);
    check(nrest == 2, "R9/R10 restore count", nrest, 2);
    check(!bad_clk, "R2 clock held", bad_clk, 0);
    check(!bad_order && !bad_space && !bad_mode, "R3/R5 pass integrity", {bad_order, bad_space, bad_mode}, 0);
    for (int i = 0; i < 40; i++) begin
      if (!(done && refresh_en && mem_clk_en && cs_n && !busy)) begin
        check(0, "R11 start ignored after done", {done, refresh_en, mem_clk_en, cs_n, busy}, 30);
        break;
      end
      @(negedge clk);
    end
    check(done && refresh_en && cs_n, "R9/R10 final state", {done, refresh_en, cs_n}, 7);
    start = 0;
  endtask

  initial begin
    do_reset();
    for (int o = 0; o < 2; o++)
      for (int f = 0; f < 2; f++)
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < 4; c++) begin
            ovr = (o == 0) ? 8'h00 : 8'h35;
            fast = f[0]; bus32 = b[0]; cas_code = c[1:0];
            run_seq(0);
            do_reset();
          end
    ovr = 0; fast = 1; bus32 = 1; cas_code = 0;
    run_seq(3);
    run_seq(0);
    do_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule